// File: doc/BRIEF.md
# Early-Page Load Address Stage

This stage sits at the front of a load pipeline and takes at most one load micro-op per clock. Each load brings a base value, a signed 32-bit displacement, an optional index and a code for what produced the base. When a load looks like part of a pointer chase, the stage starts address translation early. A pointer-chase load has a base forwarded from an earlier load, no real index, and a small non-negative displacement. The early start uses the page number of the base, before the displacement add is done. A correct guess saves one cycle. A wrong guess is detected by comparing the page bits of the sum with those of the base, and the load is then redone on the slow path at a much higher cost.

Results leave on three fixed lanes: fast completions, normal completions and replayed completions. Each lane has its own latency, so two loads never compete for one lane and issue never stalls. Each lane reports the load ID, the effective address, the latency, whether the fast guess held, and the tag that a consumer attaches to the loaded value. That tag is plain load or replayed load.

Top module: `early_page_agu`

## Requirements
- R1: While reset is held low, and in the first cycle after it is released, no lane reports a valid result.
- R2: A load whose base code is 0 (load), with no index or a zero index, a displacement of 0 to 2047 and a sum in the same 4 KiB page as the base, completes on lane 0 after LAT_FAST (4) cycles. It has fast_hit 1 and result tag 0.
- R3: A base code of 1 (ALU) or 3 (reserved) never tries the fast path. The load completes on lane 1 after LAT_NORM (5) cycles, with fast_hit 0 and tag 0, even if the sum leaves the page.
- R4: A displacement with bit 31 set (negative) or with any of bits 30 down to 11 set sends the load to lane 1. A displacement of 2047 still qualifies for the fast path; 2048 does not.
- R5: With idx_used high, an index value of zero leaves the load eligible for the fast path. A non-zero index sends it to lane 1.
- R6: The reported address is base + index (when used) + sign-extended displacement, modulo 2^48, on every lane.
- R7: A fast attempt whose sum differs from the base in any bit from 12 up completes on lane 2 after LAT_RPL (10) cycles. It has fast_hit 0 and result tag 2 (replayed load).
- R8: With STRICT set (the default), a base code of 2 (base came from a replayed load) takes lane 1. With STRICT clear, it is treated like code 0.
- R9: Each valid input is reported exactly once, on exactly one lane. A load can be accepted on every clock, and an idle input cycle produces no result.
- R10: A sum that crosses a 64-byte line but stays inside the page keeps the fast path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A load is presented this cycle |
| in_id | input | ID_W | Load identifier |
| in_base | input | 48 | Base register value |
| in_disp | input | 32 | Signed displacement |
| in_idx_used | input | 1 | Addressing form carries an index register |
| in_idx | input | 48 | Index register value |
| in_src | input | 2 | Base producer: 0 load, 1 ALU, 2 replayed load, 3 reserved |
| out_valid | output | 3 | Per-lane completion: lane 0 fast, lane 1 normal, lane 2 replay |
| out_id | output | 3*ID_W | Per-lane load identifier |
| out_ea | output | 3*48 | Per-lane effective address |
| out_lat | output | 3*LAT_W | Per-lane latency in cycles |
| out_fast_hit | output | 3 | Per-lane: the early-page guess held |
| out_src | output | 6 | Per-lane tag for the loaded value: 0 load, 2 replayed load |

## Verification
A load sampled at clock edge n shows up on its lane in the cycle that follows edge n+L-1. L is 4 on the fast lane, 5 on the normal lane and 10 on the replay lane. The bench logs every issue into a per-lane table indexed by that due cycle. It compares all three lanes at the falling edge of every cycle, so both a missing result and a result that arrives a cycle early or late show up as a mismatch. Directed page-edge, displacement-edge and wrap-around loads run first, followed by a seeded random mix in which many bases sit near the end of a page.

// File: rtl/epa_pkg.sv
package epa_pkg;
    localparam int VA_W    = 48;
    localparam int DISP_W  = 32;
    localparam int PG_BITS = 12;
    localparam int N_LANES = 3;

    typedef enum logic [1:0] {
        SRC_LOAD     = 2'd0,
        SRC_ALU      = 2'd1,
        SRC_LOAD_RPL = 2'd2,
        SRC_RSVD     = 2'd3
    } src_e;

    typedef enum logic [1:0] {
        CLS_FAST = 2'd0,
        CLS_NORM = 2'd1,
        CLS_RPL  = 2'd2,
        CLS_NONE = 2'd3
    } cls_e;
endpackage

// File: rtl/epa_gate.sv
module epa_gate
    import epa_pkg::*;
#(
    parameter bit STRICT = 1'b1
) (
    input  logic [1:0]        src,
    input  logic [DISP_W-1:0] disp,
    input  logic              idx_used,
    input  logic [VA_W-1:0]   idx,
    output logic              try_fast
);
    logic src_ok;
    logic disp_ok;
    logic idx_ok;

    always_comb begin
        src_ok   = (src == SRC_LOAD) || (!STRICT && (src == SRC_LOAD_RPL));
        // upper bits clear (sign bit included) means 0..2047, no comparator
        disp_ok  = ~|disp[DISP_W-1:PG_BITS-1];
        idx_ok   = !idx_used || (idx == '0);
        try_fast = src_ok && disp_ok && idx_ok;
    end
endmodule

// File: rtl/epa_addr.sv
module epa_addr
    import epa_pkg::*;
(
    input  logic [VA_W-1:0]   base,
    input  logic [DISP_W-1:0] disp,
    input  logic              idx_used,
    input  logic [VA_W-1:0]   idx,
    output logic [VA_W-1:0]   ea,
    output logic              page_moved
);
    logic [VA_W-1:0] disp_ext;
    logic [VA_W-1:0] idx_term;

    always_comb begin
        disp_ext   = {{(VA_W-DISP_W){disp[DISP_W-1]}}, disp};
        idx_term   = idx_used ? idx : '0;
        ea         = base + idx_term + disp_ext;
        page_moved = ea[VA_W-1:PG_BITS] != base[VA_W-1:PG_BITS];
    end
endmodule

// File: rtl/early_page_agu.sv
module early_page_agu
    import epa_pkg::*;
#(
    parameter int ID_W     = 6,
    parameter int LAT_FAST = 4,
    parameter int LAT_NORM = 5,
    parameter int LAT_RPL  = 10,
    parameter bit STRICT   = 1'b1,
    localparam int LAT_W   = $clog2(LAT_RPL + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [ID_W-1:0]           in_id,
    input  logic [VA_W-1:0]           in_base,
    input  logic [DISP_W-1:0]         in_disp,
    input  logic                      in_idx_used,
    input  logic [VA_W-1:0]           in_idx,
    input  logic [1:0]                in_src,
    output logic [N_LANES-1:0]        out_valid,
    output logic [N_LANES*ID_W-1:0]   out_id,
    output logic [N_LANES*VA_W-1:0]   out_ea,
    output logic [N_LANES*LAT_W-1:0]  out_lat,
    output logic [N_LANES-1:0]        out_fast_hit,
    output logic [N_LANES*2-1:0]      out_src
);
    localparam int DEPTH = LAT_RPL;

    typedef struct packed {
        logic            vld;
        cls_e            cls;
        logic [ID_W-1:0] id;
        logic [VA_W-1:0] ea;
    } rec_t;

    typedef struct packed {
        rec_t [DEPTH-1:0] pipe;
    } state_t;

    state_t          st_d, st_q;
    logic            try_fast;
    logic            page_moved;
    logic [VA_W-1:0] ea_now;

    epa_gate #(.STRICT(STRICT)) u_gate (
        .src      (in_src),
        .disp     (in_disp),
        .idx_used (in_idx_used),
        .idx      (in_idx),
        .try_fast (try_fast)
    );

    epa_addr u_addr (
        .base       (in_base),
        .disp       (in_disp),
        .idx_used   (in_idx_used),
        .idx        (in_idx),
        .ea         (ea_now),
        .page_moved (page_moved)
    );

    // one record per issue slot; each lane taps the stage of its own latency
    always_comb begin
        st_d = st_q;
        st_d.pipe[0].vld = in_valid;
        st_d.pipe[0].id  = in_id;
        st_d.pipe[0].ea  = ea_now;
        if (!in_valid)
            st_d.pipe[0].cls = CLS_NONE;
        else if (!try_fast)
            st_d.pipe[0].cls = CLS_NORM;
        else if (page_moved)
            st_d.pipe[0].cls = CLS_RPL;
        else
            st_d.pipe[0].cls = CLS_FAST;
        for (int k = 1; k < DEPTH; k++)
            st_d.pipe[k] = st_q.pipe[k-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    for (genvar l = 0; l < N_LANES; l++) begin : g_lane
        localparam int   TAP  = (l == 0) ? LAT_FAST : (l == 1) ? LAT_NORM : LAT_RPL;
        localparam cls_e LCLS = cls_e'(l);
        localparam src_e LSRC = (l == 2) ? SRC_LOAD_RPL : SRC_LOAD;
        rec_t tap_rec;
        assign tap_rec                     = st_q.pipe[TAP-1];
        assign out_valid[l]                = tap_rec.vld && (tap_rec.cls == LCLS);
        assign out_id[l*ID_W +: ID_W]      = tap_rec.id;
        assign out_ea[l*VA_W +: VA_W]      = tap_rec.ea;
        assign out_lat[l*LAT_W +: LAT_W]   = LAT_W'(TAP);
        assign out_fast_hit[l]             = (LCLS == CLS_FAST) && out_valid[l];
        assign out_src[l*2 +: 2]           = LSRC;
    end
endmodule

// File: rtl/early_page_agu_chk.sv
module early_page_agu_chk
    import epa_pkg::*;
#(
    parameter int ID_W     = 6,
    parameter int LAT_FAST = 4,
    parameter int LAT_NORM = 5,
    parameter int LAT_RPL  = 10,
    parameter int LAT_W    = 4
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      in_valid,
    input logic [ID_W-1:0]           in_id,
    input logic [VA_W-1:0]           in_base,
    input logic [DISP_W-1:0]         in_disp,
    input logic                      in_idx_used,
    input logic [VA_W-1:0]           in_idx,
    input logic [1:0]                in_src,
    input logic [N_LANES-1:0]        out_valid,
    input logic [N_LANES*ID_W-1:0]   out_id,
    input logic [N_LANES*VA_W-1:0]   out_ea,
    input logic [N_LANES*LAT_W-1:0]  out_lat,
    input logic [N_LANES-1:0]        out_fast_hit,
    input logic [N_LANES*2-1:0]      out_src
);
    assert_quiet_after_reset_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (out_valid == '0));

    assert_alu_base_normal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_src == SRC_ALU) |-> ##LAT_NORM
        (out_valid[1] && out_id[ID_W +: ID_W] == $past(in_id, LAT_NORM)));

    assert_neg_disp_normal_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_disp[DISP_W-1]) |-> ##LAT_NORM out_valid[1]);

    assert_real_index_normal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_idx_used && in_idx != '0) |-> ##LAT_NORM out_valid[1]);

    assert_idle_no_fast_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##LAT_FAST !out_valid[0]);
endmodule

bind early_page_agu early_page_agu_chk #(
    .ID_W(ID_W), .LAT_FAST(LAT_FAST), .LAT_NORM(LAT_NORM),
    .LAT_RPL(LAT_RPL), .LAT_W(LAT_W)
) u_chk (.*);

// File: tb/test_early_page_agu.sv
module test_early_page_agu;
    localparam int ID_W  = 6;
    localparam int LAT_W = 4;
    localparam int NL    = 3;
    localparam int SL    = 64;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 in_valid = 1'b0;
    logic [ID_W-1:0]      in_id = '0;
    logic [47:0]          in_base = '0;
    logic [31:0]          in_disp = '0;
    logic                 in_idx_used = 1'b0;
    logic [47:0]          in_idx = '0;
    logic [1:0]           in_src = '0;
    logic [NL-1:0]        out_valid;
    logic [NL*ID_W-1:0]   out_id;
    logic [NL*48-1:0]     out_ea;
    logic [NL*LAT_W-1:0]  out_lat;
    logic [NL-1:0]        out_fast_hit;
    logic [NL*2-1:0]      out_src;

    early_page_agu i_early_page_agu (.*);

    always #2 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    logic [ID_W-1:0] next_id = '0;
    bit              exp_v   [NL][SL];
    logic [ID_W-1:0] exp_id  [NL][SL];
    logic [47:0]     exp_ea  [NL][SL];
    string           exp_tag [NL][SL];

    function automatic int lane_lat(int l);
        return (l == 0) ? 4 : (l == 1) ? 5 : 10;
    endfunction

    function automatic logic [47:0] model_ea(logic [47:0] b, logic [31:0] d,
                                             bit iu, logic [47:0] ix);
        longint sd = longint'($signed(d));
        longint sum = longint'(b) + (iu ? longint'(ix) : 64'd0) + sd;
        return sum[47:0];
    endfunction

    function automatic int model_lane(logic [1:0] s, logic [47:0] b, logic [31:0] d,
                                      bit iu, logic [47:0] ix);
        bit ok = (s == 2'd0) && (d < 32'd2048) && (!iu || ix == 48'd0);
        logic [47:0] e = model_ea(b, d, iu, ix);
        if (!ok) return 1;
        return ((e >> 12) == (b >> 12)) ? 0 : 2;
    endfunction

    task automatic check_now();
        int s = cyc % SL;
        for (int l = 0; l < NL; l++) begin
            bit              av = out_valid[l];
            logic [ID_W-1:0] ai = out_id[l*ID_W +: ID_W];
            logic [47:0]     ae = out_ea[l*48 +: 48];
            logic [3:0]      al = out_lat[l*LAT_W +: LAT_W];
            bit              af = out_fast_hit[l];
            logic [1:0]      as = out_src[l*2 +: 2];
            string tg = exp_v[l][s] ? exp_tag[l][s] : "R9";
            n_chk++;
            if (av !== exp_v[l][s]) begin
                n_bad++;
                $display("FAIL %s lane%0d cyc%0d valid act=%0b exp=%0b", tg, l, cyc, av, exp_v[l][s]);
            end else if (exp_v[l][s] && (ai !== exp_id[l][s] || ae !== exp_ea[l][s] ||
                         al !== 4'(lane_lat(l)) || af !== (l == 0) ||
                         as !== ((l == 2) ? 2'd2 : 2'd0))) begin
                n_bad++;
                $display("FAIL %s lane%0d cyc%0d act id=%0d ea=%h lat=%0d hit=%0b src=%0d exp id=%0d ea=%h lat=%0d hit=%0b src=%0d",
                         tg, l, cyc, ai, ae, al, af, as, exp_id[l][s], exp_ea[l][s],
                         lane_lat(l), (l == 0), (l == 2) ? 2 : 0);
            end
            exp_v[l][s] = 1'b0;
        end
    endtask

    task automatic step();
        @(posedge clk);
        cyc++;
        @(negedge clk);
        check_now();
    endtask

    task automatic issue(string tg, logic [1:0] s, logic [47:0] b, logic [31:0] d,
                         bit iu, logic [47:0] ix);
        int l = model_lane(s, b, d, iu, ix);
        int slot = (cyc + lane_lat(l)) % SL;
        in_valid = 1'b1; in_id = next_id; in_src = s; in_base = b;
        in_disp = d; in_idx_used = iu; in_idx = ix;
        exp_v[l][slot] = 1'b1; exp_id[l][slot] = next_id;
        exp_ea[l][slot] = model_ea(b, d, iu, ix); exp_tag[l][slot] = tg;
        next_id++;
        step();
    endtask

    task automatic idle();
        in_valid = 1'b0;
        in_base = 48'hDEAD_0000_0FF8; in_disp = 32'd8; in_src = 2'd0;
        step();
    endtask

    initial begin
        #(4 * 150000);
        n_bad++; n_chk++;
        $display("FAIL R9 watchdog act=timeout exp=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd1357);
        for (int l = 0; l < NL; l++)
            for (int s = 0; s < SL; s++) exp_v[l][s] = 1'b0;
        // R1: quiet during and right after reset
        repeat (3) begin
            @(negedge clk);
            n_chk++;
            if (out_valid !== 3'b000) begin
                n_bad++;
                $display("FAIL R1 reset act=%b exp=000", out_valid);
            end
        end
        rst_n = 1'b1;
        idle();
        // directed corners, back to back (R9 throughput)
        issue("R2",  2'd0, 48'h0000_0000_1000, 32'd8, 1'b0, '0);
        issue("R7",  2'd0, 48'h0000_0000_1FF8, 32'd8, 1'b0, '0);
        issue("R10", 2'd0, 48'h0000_0000_1038, 32'h10, 1'b0, '0);
        issue("R3",  2'd1, 48'h0000_0000_1000, 32'd8, 1'b0, '0);
        issue("R3",  2'd1, 48'h0000_0000_1FF8, 32'd8, 1'b0, '0);
        issue("R3",  2'd3, 48'h0000_0000_2000, 32'd4, 1'b0, '0);
        issue("R4",  2'd0, 48'h0000_0000_5000, 32'd2047, 1'b0, '0);
        issue("R4",  2'd0, 48'h0000_0000_5000, 32'd2048, 1'b0, '0);
        issue("R4",  2'd0, 48'h0000_0000_1008, 32'hFFFF_FFF8, 1'b0, '0);
        issue("R4",  2'd0, 48'h0000_0000_5000, 32'h0010_0000, 1'b0, '0);
        issue("R5",  2'd0, 48'h0000_0000_3000, 32'd16, 1'b1, 48'd0);
        issue("R5",  2'd0, 48'h0000_0000_3000, 32'd16, 1'b1, 48'h40);
        issue("R8",  2'd2, 48'h0000_0000_3000, 32'd16, 1'b0, '0);
        issue("R6",  2'd1, 48'hFFFF_FFFF_FFF0, 32'h20, 1'b0, '0);
        issue("R7",  2'd0, 48'h0000_0000_6FFF, 32'd2047, 1'b0, '0);
        issue("R2",  2'd0, 48'h0000_0000_7000, 32'd0, 1'b0, '0);
        idle();
        issue("R9",  2'd0, 48'h0000_0000_7000, 32'd0, 1'b0, '0);
        repeat (12) idle();
        // seeded random mix
        for (int i = 0; i < 800; i++) begin
            if ($urandom % 5 == 0) idle();
            else begin
                logic [47:0] b = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
                logic [31:0] d;
                bit iu = ($urandom % 4 == 0);
                logic [47:0] ix = ($urandom % 2) ? 48'd0 : 48'({$urandom} % 8192);
                int pick = $urandom % 4;
                if ($urandom % 2) b[11:0] = 12'hFC0 | 12'($urandom % 64);
                d = (pick == 0) ? 32'($urandom % 2048) :
                    (pick == 1) ? 32'(2040 + $urandom % 16) :
                    (pick == 2) ? -32'($urandom % 64) : $urandom;
                issue("R6", 2'($urandom % 4), b, d, iu, ix);
            end
        end
        repeat (12) idle();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule